// File: doc/BRIEF.md
# Parallel EPROM Read Cycle Controller

This block lets synchronous logic fetch single bytes from a bank of asynchronous parallel EPROM devices. The host presents a request with a byte address. The upper address bits pick one device in the bank and the lower bits go out on the shared address bus. The controller pulls the chip enable of the picked device low and leaves every other device deselected, so those devices stay in standby. It then waits out the access time in clock cycles, captures the byte and hands it back with a one-cycle valid pulse.

One output-enable line is common to all devices. The controller drives it low late in the cycle: the address and the chip enable go out first, and output enable follows once only the output-enable access time is left of the address access time. All wait counts come from nanosecond parameters and the clock period, each rounded up to whole cycles. When a read targets a different device from the previous read, a float wait with all enables high comes first. This stops the old device's drivers from overlapping the new device's drivers. A read of the same device skips that wait.

Top module: `eprom_read_ctrl`

## Requirements
- R1: During and right after reset, every chip-enable line and the output enable are high (inactive), `rsp_valid` is low and `req_ready` is high.
- R2: Bits `[16:15]` of the request address select the device, and only that device's chip enable goes low for the read. At most one chip enable is ever low.
- R3: `mem_addr` carries request address bits `[14:0]`. It stays unchanged for as long as a chip enable is low. The address and the chip enable are valid for at least the address access time (90 ns at defaults) before the data is sampled.
- R4: Output enable goes low only while a chip enable is low. With defaults it goes low 7 cycles after the chip enable and stays low for 5 cycles (ceil(40/8)) before the sample.
- R5: With defaults (8 ns clock, 90 ns access), the chip enable is low for exactly 12 cycles. The data is sampled at the clock edge that ends that window. `rsp_valid` rises 12 cycles after the accepting edge when no float wait is needed.
- R6: When the accepted device differs from the device of the previous accepted read, the chip enable is held off for ceil(25/8)=4 extra cycles (latency 16). The next output enable never falls within 25 ns of the previous one rising while a different device is selected.
- R7: `rsp_valid` is a single-cycle pulse, and `rsp_data` then holds the byte the selected device drove at the sample edge.
- R8: A request is accepted only while `req_ready` is high. A `req_valid` raised while the controller is busy is ignored: it produces no response, leaves `mem_addr` unchanged and does not count as the previous device.
- R9: In the cycle that `rsp_valid` is high, all chip enables and the output enable are already back high.
- R10: The first read after reset has no float wait (latency 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | 17 | Device select (upper 2 bits) and byte address (lower 15 bits) |
| req_ready | output | 1 | High when idle; a request is taken on an edge where both are high |
| rsp_valid | output | 1 | One-cycle pulse marking returned data |
| rsp_data | output | 8 | Byte read from the device |
| mem_addr | output | 15 | Shared address bus to the devices |
| mem_ce_n | output | 4 | Active-low chip enable, one per device |
| mem_oe_n | output | 1 | Active-low output enable shared by all devices |
| mem_data_in | input | 8 | Data bus from the devices |

## Verification
The bench runs several request patterns: repeated reads of one device, pairs on the same device, strict alternation between devices, back-to-back requests, and reads after idle gaps. Same-device pairs against device changes show whether the float wait is added only when the target changes. This appears as a latency of 12 or 16 cycles. The first read after reset shows whether a phantom previous device exists. The bench device model time-stamps every enable and address edge, so the access, output-enable and float times are measured in nanoseconds and not just inferred from cycle counts. A request raised while busy tests that it is neither answered nor allowed to change the address or the device history.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_FLOAT  = 2'd1,
        RD_SETUP  = 2'd2,
        RD_ACCESS = 2'd3
    } rd_phase_e;

    // Control bundle from the sequencer to the bus side.
    typedef struct packed {
        logic idle;    // ready for a new request
        logic ce_on;   // selected device enabled
        logic oe_on;   // shared output enable active
        logic grab;    // sample the data bus at this edge
    } bus_ctl_t;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned period_ns);
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to index n items (at least one).
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/eprom_cycle_timer.sv
`timescale 1ns/1ps
module eprom_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // An expired timer stays expired until reloaded, so a wait never wraps.
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt_q) == '0) |-> (cnt_q == '0)); // R5

endmodule

// File: rtl/eprom_ce_decoder.sv
`timescale 1ns/1ps
module eprom_ce_decoder #(
    parameter int unsigned NUM_DEV = 4,
    parameter int unsigned SEL_W   = 2
) (
    input  logic               enable,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_DEV-1:0] ce_n
);

    generate
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            assign ce_n[d] = !(enable && (sel == SEL_W'(d)));
        end
    endgenerate

endmodule

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int unsigned FLOAT_CYC  = 4,
    parameter int unsigned SETUP_CYC  = 7,
    parameter int unsigned ACCESS_CYC = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     dev_change,
    output bus_ctl_t ctl
);

    localparam int unsigned LONGEST = max2(max2(FLOAT_CYC, SETUP_CYC), ACCESS_CYC);
    localparam int unsigned CNT_W   = width_for(LONGEST);
    localparam logic [CNT_W-1:0] FLOAT_LD  = CNT_W'(sat_sub(FLOAT_CYC, 1));
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(sat_sub(SETUP_CYC, 1));
    localparam logic [CNT_W-1:0] ACCESS_LD = CNT_W'(sat_sub(ACCESS_CYC, 1));

    rd_phase_e        phase_q, phase_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             grab;
    logic             ce_on;
    logic             oe_on;

    eprom_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        grab     = 1'b0;
        unique case (phase_q)
            RD_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    if (dev_change && (FLOAT_CYC > 0)) begin
                        phase_d = RD_FLOAT;
                        tmr_val = FLOAT_LD;
                    end else if (SETUP_CYC > 0) begin
                        phase_d = RD_SETUP;
                        tmr_val = SETUP_LD;
                    end else begin
                        phase_d = RD_ACCESS;
                        tmr_val = ACCESS_LD;
                    end
                end
            end
            RD_FLOAT: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (SETUP_CYC > 0) begin
                        phase_d = RD_SETUP;
                        tmr_val = SETUP_LD;
                    end else begin
                        phase_d = RD_ACCESS;
                        tmr_val = ACCESS_LD;
                    end
                end
            end
            RD_SETUP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    phase_d  = RD_ACCESS;
                    tmr_val  = ACCESS_LD;
                end
            end
            RD_ACCESS: begin
                if (tmr_done) begin
                    grab    = 1'b1;
                    phase_d = RD_IDLE;
                end
            end
            default: phase_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= RD_IDLE;
        else
            phase_q <= phase_d;
    end

    assign ce_on = (phase_q == RD_SETUP) || (phase_q == RD_ACCESS);
    assign oe_on = (phase_q == RD_ACCESS);

    assign ctl.idle  = (phase_q == RD_IDLE);
    assign ctl.ce_on = ce_on;
    assign ctl.oe_on = oe_on;
    assign ctl.grab  = grab;

    generate
        if (SETUP_CYC > 0) begin : g_late_oe
            // Output enable only follows an enable that was already on.
            AST_OE_LATE: assert property (@(posedge clk) disable iff (rst)
                $rose(oe_on) |-> $past(ce_on)); // R4
        end
        if (FLOAT_CYC > 0) begin : g_float
            // A request for another device keeps the enables off first.
            AST_FLOAT_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
                (start && ctl.idle && dev_change) |=> !ce_on); // R6
        end
    endgenerate

endmodule

// File: rtl/eprom_read_ctrl.sv
`timescale 1ns/1ps
module eprom_read_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_ACC_NS      = 90,
    parameter int unsigned T_OE_NS       = 40,
    parameter int unsigned T_FLOAT_NS    = 25,
    parameter int unsigned NUM_DEV       = 4,
    parameter int unsigned DEV_AW        = 15,
    parameter int unsigned DATA_W        = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   req_valid,
    input  logic [DEV_AW+width_for(NUM_DEV)-1:0]   req_addr,
    output logic                                   req_ready,
    output logic                                   rsp_valid,
    output logic [DATA_W-1:0]                      rsp_data,
    output logic [DEV_AW-1:0]                      mem_addr,
    output logic [NUM_DEV-1:0]                     mem_ce_n,
    output logic                                   mem_oe_n,
    input  logic [DATA_W-1:0]                      mem_data_in
);

    localparam int unsigned SEL_W      = width_for(NUM_DEV);
    localparam int unsigned HOST_AW    = DEV_AW + SEL_W;
    localparam int unsigned ACC_CYC    = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int unsigned OE_CYC     = max2(ns_to_cycles(T_OE_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned FLOAT_CYC  = ns_to_cycles(T_FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned SETUP_CYC  = sat_sub(ACC_CYC, OE_CYC);

    bus_ctl_t           ctl;
    logic               accept;
    logic               dev_change;
    logic [SEL_W-1:0]   req_dev;
    logic [SEL_W-1:0]   dev_q;
    logic               have_dev_q;
    logic [DEV_AW-1:0]  addr_q;
    logic               rsp_valid_q;
    logic [DATA_W-1:0]  rsp_data_q;

    assign req_dev    = req_addr[HOST_AW-1 -: SEL_W];
    assign req_ready  = ctl.idle;
    assign accept     = req_valid && ctl.idle;
    assign dev_change = have_dev_q && (req_dev != dev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            dev_q      <= '0;
            have_dev_q <= 1'b0;
        end else if (accept) begin
            addr_q     <= req_addr[DEV_AW-1:0];
            dev_q      <= req_dev;
            have_dev_q <= 1'b1;
        end
    end

    eprom_rd_seq #(
        .FLOAT_CYC  (FLOAT_CYC),
        .SETUP_CYC  (SETUP_CYC),
        .ACCESS_CYC (OE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .dev_change (dev_change),
        .ctl        (ctl)
    );

    eprom_ce_decoder #(
        .NUM_DEV (NUM_DEV),
        .SEL_W   (SEL_W)
    ) u_dec (
        .enable (ctl.ce_on),
        .sel    (dev_q),
        .ce_n   (mem_ce_n)
    );

    assign mem_addr = addr_q;
    assign mem_oe_n = !ctl.oe_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= ctl.grab;
            if (ctl.grab)
                rsp_data_q <= mem_data_in;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_ce_n) <= 1); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_ce_n) && !(&$past(mem_ce_n))) |-> $stable(mem_addr)); // R3
    AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !(&mem_ce_n)); // R4
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R7
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(mem_addr)); // R8
    AST_RELEASED_AT_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((&mem_ce_n) && mem_oe_n)); // R9

endmodule

// File: tb/sim_eprom_read_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_read_ctrl;

    localparam int LAT_BASE  = 12;
    localparam int LAT_FLOAT = 4;
    localparam int CE_LOW    = 12;
    localparam int OE_LOW    = 5;

    typedef struct {
        logic [7:0] data;
        int         due;
        int         dev;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [14:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_data_in;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int issued = 0;
    int answered = 0;
    int last_dev_b = -1;
    int ce_cnt = 0;
    int oe_cnt = 0;
    int wrong_sel = 0;
    int contention = 0;
    int oe_dev = -1;
    int prev_oe_dev = -1;
    bit done = 1'b0;
    exp_t exp_q[$];

    realtime t_edge = 0.0;
    realtime t_ce_fall = 0.0;
    realtime t_oe_fall = 0.0;
    realtime t_oe_rise = -100.0;
    realtime t_addr = 0.0;

    always #4 clk = ~clk;

    eprom_read_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .mem_addr    (mem_addr),
        .mem_ce_n    (mem_ce_n),
        .mem_oe_n    (mem_oe_n),
        .mem_data_in (mem_data_in)
    );

    function automatic logic [7:0] rom_byte(input int dev, input logic [14:0] a);
        logic [7:0] dv;
        dv = 8'(dev);
        return a[7:0] ^ {1'b0, a[14:8]} ^ (8'h3C + dv * 8'h47);
    endfunction

    function automatic int sel_dev(input logic [3:0] ce_n);
        int r;
        r = -1;
        for (int d = 0; d < 4; d++)
            if (!ce_n[d]) r = d;
        return r;
    endfunction

    // Device bank model: the enabled device drives its byte.
    always_comb begin
        mem_data_in = 8'h00;
        for (int d = 0; d < 4; d++)
            if (!mem_ce_n[d] && !mem_oe_n)
                mem_data_in = rom_byte(d, mem_addr);
    end

    logic any_ce;
    assign any_ce = ~&mem_ce_n;

    always @(posedge clk) begin
        cyc    = cyc + 1;
        t_edge = $realtime;
    end
    always @(posedge any_ce) t_ce_fall = $realtime;
    always @(mem_addr) t_addr = $realtime;
    always @(negedge mem_oe_n) begin
        t_oe_fall = $realtime;
        oe_dev    = sel_dev(mem_ce_n);
        if (prev_oe_dev >= 0 && oe_dev != prev_oe_dev && ($realtime - t_oe_rise) < 25.0)
            contention = contention + 1;
    end
    always @(posedge mem_oe_n) begin
        t_oe_rise   = $realtime;
        prev_oe_dev = oe_dev;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Driver: issue one read and queue the expected result.
    task automatic rd(input int dev, input logic [14:0] a);
        exp_t e;
        int   lat;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {2'(dev), a};
        while (!req_ready) @(negedge clk);
        lat   = LAT_BASE;
        e.tag = (last_dev_b < 0) ? "R10" : "R5";
        if (last_dev_b >= 0 && dev != last_dev_b) begin
            lat   = LAT_BASE + LAT_FLOAT;
            e.tag = "R6";
        end
        e.data = rom_byte(dev, a);
        e.due  = cyc + 1 + lat;
        e.dev  = dev;
        exp_q.push_back(e);
        issued     = issued + 1;
        last_dev_b = dev;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    // Monitor / scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (any_ce) begin
                    ce_cnt = ce_cnt + 1;
                    if (exp_q.size() == 0 || mem_ce_n != ~(4'b0001 << exp_q[0].dev))
                        wrong_sel = wrong_sel + 1;
                end
                if (!mem_oe_n) oe_cnt = oe_cnt + 1;
                if (rsp_valid) begin
                    answered = answered + 1;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected response", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(rsp_data == e.data, "R7", "data", int'(rsp_data), int'(e.data));
                        check(cyc == e.due, e.tag, "response cycle", cyc, e.due);
                        check(ce_cnt == CE_LOW, "R5", "ce low cycles", ce_cnt, CE_LOW);
                        check(oe_cnt == OE_LOW, "R4", "oe low cycles", oe_cnt, OE_LOW);
                        check(wrong_sel == 0, "R2", "wrong select cycles", wrong_sel, 0);
                        check((&mem_ce_n) && mem_oe_n, "R9", "enables released",
                              int'({mem_ce_n, mem_oe_n}), 31);
                        check((t_edge - t_ce_fall) >= 90.0, "R3", "ce to sample ns",
                              int'(t_edge - t_ce_fall), 90);
                        check((t_edge - t_addr) >= 90.0, "R3", "addr to sample ns",
                              int'(t_edge - t_addr), 90);
                        check((t_edge - t_oe_fall) >= 40.0, "R4", "oe to sample ns",
                              int'(t_edge - t_oe_fall), 40);
                    end
                    ce_cnt    = 0;
                    oe_cnt    = 0;
                    wrong_sel = 0;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check(&mem_ce_n, "R1", "ce during reset", int'(mem_ce_n), 15);
        check(mem_oe_n, "R1", "oe during reset", int'(mem_oe_n), 1);
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(&mem_ce_n, "R1", "ce after reset", int'(mem_ce_n), 15);
        check(mem_oe_n, "R1", "oe after reset", int'(mem_oe_n), 1);
        check(!rsp_valid, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check(req_ready, "R1", "ready after reset", int'(req_ready), 1);

        // R10 first read, then same-device pair, then switches.
        rd(0, 15'h0000);
        rd(0, 15'h7FFF);
        rd(1, 15'h1234);
        rd(1, 15'h1235);
        rd(3, 15'h7FFF);
        rd(2, 15'h0000);
        // Pairs and alternation, back to back.
        for (int i = 0; i < 12; i++)
            rd((i / 2) % 4, 15'(i * 16'h0A5B));
        for (int i = 0; i < 6; i++)
            rd((i % 2 == 0) ? 2 : 3, 15'(16'h4000 + i * 7));
        drain();

        // R8: request raised while busy is ignored.
        rd(2, 15'h0123);
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {2'd3, 15'h7777};
        check(!req_ready, "R8", "ready while busy", int'(req_ready), 0);
        @(negedge clk);
        check(mem_addr == 15'h0123, "R8", "addr while busy", int'(mem_addr), 16'h0123);
        req_valid = 1'b0;
        drain();
        // Previous device must still be 2: same device, no float.
        rd(2, 15'h0456);
        // Idle gap, then a device change still waits for float.
        repeat (20) @(negedge clk);
        rd(1, 15'h3333);
        drain();

        check(answered == issued, "R8", "responses", answered, issued);
        check(contention == 0, "R6", "bus overlap events", contention, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule